// File: doc/BRIEF.md
# Chip-Select Parallel Slave Port

This block is the slave end of an 8-bit parallel link. An external master reaches it through an active-low chip select, a direction line and a data bus. The bus is split here into an input byte, an output byte and an output enable, and a pad cell outside the block joins them into one bidirectional bus. All three control inputs are asynchronous to the local system clock. Each one passes through a synchronizer chain, and every decision is taken on the synchronized copies.

When the master releases chip select, the block treats the access as complete. It then raises a busy handshake and keeps it high for at least a fixed number of clocks. The handshake drops only when the user side is ready for the next transfer. After a write, that means the captured byte has been taken through a valid/ready output. After a read, it means a fresh byte has been loaded through a valid/ready input and has been on the bus for a minimum lead time. An access that the master starts while the handshake is high is dropped, and it sets a sticky error flag. The user side clears that flag with a pulse.

Top module: `cs_slave_port`

## Requirements
- R1: While `rst` is high, `hsBusy` is 1, `dataOe` is 0, `wrValid` is 0 and `errFlag` is 0. After `rst` falls, `hsBusy` stays 1 for exactly 4 clocks and then falls, because no transfer is pending.
- R2: The transfer direction is taken from `rdWr` when chip select falls (1 = read, 0 = write). A change of `rdWr` later in the same access does not change how that access is completed.
- R3: After an accepted access, `hsBusy` is 1 on the third clock edge after `csN` rises. This is two synchronizer stages plus one register.
- R4: Once raised, `hsBusy` stays high for at least 4 clocks. When the user side is already ready, it stays high for exactly 4.
- R5: `dataOe` follows the synchronized `rdWr` with three clocks of latency, whether or not chip select is active. It is 1 in the read direction and 0 (bus released) in the write direction.
- R6: A write access captures `dataIn` at the detected chip-select release and presents it on `wrData` with `wrValid` = 1. Both stay fixed until `wrReady` is seen. `hsBusy` stays high until the byte has been accepted.
- R7: A byte offered on `rdData` with `rdValid` is loaded when `rdReady` is 1. It then appears on `dataOut`, and `rdReady` drops to 0. A read access consumes the byte, which sets `rdReady` back to 1. `hsBusy` stays high until a new byte is loaded.
- R8: After a read access, `hsBusy` falls no earlier than the third clock after the new byte is loaded. The byte is therefore on `dataOut` for at least 2 full clocks before the handshake falls.
- R9: A loaded read byte on `dataOut` does not change until the read access that consumes it has completed.
- R10: An access whose chip-select fall is detected while `hsBusy` is 1 is ignored: it captures nothing and consumes nothing. It sets `errFlag`, which stays 1 until an `errClr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Active-low chip select from the master (asynchronous) |
| rdWr | input | 1 | Direction from the master, 1 = read (asynchronous) |
| dataIn | input | 8 | Byte seen on the bus |
| dataOut | output | 8 | Byte presented to the bus on reads |
| dataOe | output | 1 | Bus output enable |
| hsBusy | output | 1 | Handshake, high while the slave is not ready |
| wrData | output | 8 | Byte captured by a write access |
| wrValid | output | 1 | wrData holds an unaccepted byte |
| wrReady | input | 1 | User accepts wrData |
| rdData | input | 8 | Byte offered for the next read |
| rdValid | input | 1 | rdData is valid |
| rdReady | output | 1 | Read buffer is empty and can load |
| errFlag | output | 1 | Sticky flag for an ignored access |
| errClr | input | 1 | Pulse that clears errFlag |

## Verification
Assertions check four properties on every cycle. The handshake stays high for its minimum run. An accepted release always raises the handshake. The latched direction holds while chip select stays low. An unaccepted write byte and a loaded read byte stay stable. Alongside these, the output enable tracks the direction strobe, and an access during busy sets the error flag. Some outcomes can only be shown by the directed scenarios: the exact cycle in which the handshake falls after reset and after each user action, the read-data lead before the falling handshake, and the fact that a direction flip in the middle of an access or an access during busy leaves the user-side ports untouched.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef struct packed {
    logic captureWr;
    logic consumeRd;
    logic driveBus;
  } spsStrobe_t;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_WR   = 2'd1,
    PEND_RD   = 2'd2
  } pendKind_e;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int MIN_HIGH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdWr,
  input  logic       wrPending,
  input  logic       rdOk,
  input  logic       errClr,
  output spsStrobe_t strobe,
  output logic       hsBusy,
  output logic       errFlag
);
  localparam int CW = $clog2(MIN_HIGH + 1);

  logic [1:0] syncOut;
  logic       csSync, rwSync, csPrev;
  logic       csFall, csRise;
  logic       dirRead, ignoreAcc, readyNow;
  logic [CW-1:0] cnt;
  pendKind_e  pend;

  sps_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) sync_i (
    .clk(clk), .rst(rst), .asyncIn({csN, rdWr}), .syncOut(syncOut)
  );
  assign csSync = syncOut[1];
  assign rwSync = syncOut[0];

  assign csFall = csPrev & ~csSync;
  assign csRise = ~csPrev & csSync;

  always_comb begin
    case (pend)
      PEND_WR: readyNow = ~wrPending;
      PEND_RD: readyNow = rdOk;
      default: readyNow = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csPrev    <= 1'b1;
      dirRead   <= 1'b0;
      ignoreAcc <= 1'b0;
      errFlag   <= 1'b0;
      hsBusy    <= 1'b1;
      cnt       <= '0;
      pend      <= PEND_NONE;
    end else begin
      csPrev <= csSync;
      if (csFall) begin
        dirRead   <= rwSync;
        ignoreAcc <= hsBusy;
      end
      if (csFall && hsBusy) errFlag <= 1'b1;
      else if (errClr)      errFlag <= 1'b0;

      if (csRise && !ignoreAcc) begin
        hsBusy <= 1'b1;
        cnt    <= '0;
        pend   <= dirRead ? PEND_RD : PEND_WR;
      end else if (hsBusy) begin
        if (cnt < CW'(MIN_HIGH - 1)) cnt <= cnt + 1'b1;
        else if (readyNow) begin
          hsBusy <= 1'b0;
          pend   <= PEND_NONE;
        end
      end
    end
  end

  assign strobe.captureWr = csRise & ~ignoreAcc & ~dirRead;
  assign strobe.consumeRd = csRise & ~ignoreAcc & dirRead;
  assign strobe.driveBus  = rwSync;

  // Independent run-length counter of the handshake for the minimum check
  logic [CW-1:0] hiRun;
  always_ff @(posedge clk) begin
    if (rst)         hiRun <= '0;
    else if (hsBusy) hiRun <= (hiRun == CW'(MIN_HIGH)) ? hiRun : hiRun + 1'b1;
    else             hiRun <= '0;
  end

  // R4
  hs_min_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hsBusy) |-> hiRun >= CW'(MIN_HIGH));

  // R3
  hs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (csRise && !ignoreAcc) |=> hsBusy);

  // R10
  busy_err_chk: assert property (@(posedge clk) disable iff (rst)
    (csFall && hsBusy) |=> errFlag);

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!csPrev && !csSync) |=> $stable(dirRead));
endmodule

// File: rtl/sps_dpath.sv
module sps_dpath
  import sps_pkg::*;
#(
  parameter int W = 8,
  parameter int LEAD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  spsStrobe_t   strobe,
  input  logic [W-1:0] dataIn,
  input  logic         wrReady,
  input  logic [W-1:0] rdData,
  input  logic         rdValid,
  output logic [W-1:0] wrData,
  output logic         wrValid,
  output logic         rdReady,
  output logic [W-1:0] dataOut,
  output logic         dataOe,
  output logic         rdOk
);
  localparam int AW = $clog2(LEAD + 1);

  logic          rdFull;
  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrValid <= 1'b0;
      wrData  <= '0;
    end else if (strobe.captureWr) begin
      wrValid <= 1'b1;
      wrData  <= dataIn;
    end else if (wrReady) begin
      wrValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdFull  <= 1'b0;
      dataOut <= '0;
      age     <= '0;
    end else if (strobe.consumeRd) begin
      rdFull <= 1'b0;
    end else if (rdValid && !rdFull) begin
      rdFull  <= 1'b1;
      dataOut <= rdData;
      age     <= '0;
    end else if (rdFull && age < AW'(LEAD)) begin
      age <= age + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dataOe <= 1'b0;
    else     dataOe <= strobe.driveBus;
  end

  assign rdReady = ~rdFull;
  assign rdOk    = rdFull & (age >= AW'(LEAD));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !wrReady && !strobe.captureWr) |=> (wrValid && $stable(wrData)));

  // R9
  rd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rdFull && !strobe.consumeRd) |=> $stable(dataOut));

  // R5
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.driveBus |=> dataOe);

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.driveBus |=> !dataOe);
endmodule

// File: rtl/cs_slave_port.sv
module cs_slave_port
  import sps_pkg::*;
#(
  parameter int W = 8,
  parameter int MIN_HIGH = 4,
  parameter int LEAD = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         csN,
  input  logic         rdWr,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] dataOut,
  output logic         dataOe,
  output logic         hsBusy,
  output logic [W-1:0] wrData,
  output logic         wrValid,
  input  logic         wrReady,
  input  logic [W-1:0] rdData,
  input  logic         rdValid,
  output logic         rdReady,
  output logic         errFlag,
  input  logic         errClr
);
  spsStrobe_t strobe;
  logic       rdOk;

  sps_ctrl #(.MIN_HIGH(MIN_HIGH), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .csN(csN), .rdWr(rdWr),
    .wrPending(wrValid), .rdOk(rdOk), .errClr(errClr),
    .strobe(strobe), .hsBusy(hsBusy), .errFlag(errFlag)
  );

  sps_dpath #(.W(W), .LEAD(LEAD)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .dataIn(dataIn),
    .wrReady(wrReady), .rdData(rdData), .rdValid(rdValid),
    .wrData(wrData), .wrValid(wrValid), .rdReady(rdReady),
    .dataOut(dataOut), .dataOe(dataOe), .rdOk(rdOk)
  );
endmodule

// File: tb/cs_slave_port_tb.sv
module cs_slave_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1;
  logic       rdWr = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe, hsBusy, wrValid, rdReady, errFlag;
  logic [7:0] wrData;
  logic       wrReady = 1'b0;
  logic [7:0] rdData = '0;
  logic       rdValid = 1'b0;
  logic       errClr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cs_slave_port dut_i (
    .clk(clk), .rst(rst), .csN(csN), .rdWr(rdWr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .hsBusy(hsBusy),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .errFlag(errFlag), .errClr(errClr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one access and ends on the negedge right after csN rises
  task automatic access(input bit rd, input logic [7:0] b);
    rdWr = rd; dataIn = b;
    cyc(1);
    csN = 1'b0;
    cyc(4);
    csN = 1'b1;
  endtask

  task automatic t_reset;
    cyc(3);
    check(hsBusy == 1'b1, "R1 hs in reset", hsBusy, 1);
    check(dataOe == 1'b0, "R1 oe in reset", dataOe, 0);
    check(wrValid == 1'b0 && errFlag == 1'b0, "R1 valid/err in reset", {wrValid, errFlag}, 0);
    rst = 1'b0;
    cyc(3);
    check(hsBusy == 1'b1, "R1 hs high 3 clocks after reset", hsBusy, 1);
    cyc(1);
    check(hsBusy == 1'b0, "R1 hs low 4 clocks after reset", hsBusy, 0);
  endtask

  task automatic t_write;
    access(1'b0, 8'hA5);
    cyc(2);
    check(hsBusy == 1'b0, "R3 hs not yet up", hsBusy, 0);
    cyc(1);
    check(hsBusy == 1'b1, "R3 hs up 3 clocks after release", hsBusy, 1);
    check(wrValid == 1'b1 && wrData == 8'hA5, "R6 byte captured", wrData, 8'hA5);
    cyc(8);
    check(hsBusy == 1'b1 && wrValid == 1'b1, "R6 hs held until accept", hsBusy, 1);
    wrReady = 1'b1;
    cyc(1);
    wrReady = 1'b0;
    check(wrValid == 1'b0, "R6 byte accepted", wrValid, 0);
    cyc(1);
    check(hsBusy == 1'b0, "R6 hs falls after accept", hsBusy, 0);
  endtask

  task automatic t_read;
    rdData = 8'h3C; rdValid = 1'b1;
    cyc(1);
    rdValid = 1'b0;
    check(rdReady == 1'b0 && dataOut == 8'h3C, "R7 byte loaded", dataOut, 8'h3C);
    rdWr = 1'b1;
    cyc(2);
    check(dataOe == 1'b0, "R5 oe latency", dataOe, 0);
    cyc(1);
    check(dataOe == 1'b1, "R5 oe follows read direction", dataOe, 1);
    csN = 1'b0;
    cyc(4);
    check(dataOut == 8'h3C, "R9 read byte stable during access", dataOut, 8'h3C);
    csN = 1'b1;
    cyc(3);
    check(hsBusy == 1'b1 && rdReady == 1'b1, "R7 byte consumed, hs up", {hsBusy, rdReady}, 3);
    cyc(8);
    check(hsBusy == 1'b1, "R7 hs held with no byte", hsBusy, 1);
    rdData = 8'h81; rdValid = 1'b1;
    cyc(1);
    rdValid = 1'b0;
    cyc(2);
    check(hsBusy == 1'b1 && dataOut == 8'h81, "R8 hs held during data lead", hsBusy, 1);
    cyc(1);
    check(hsBusy == 1'b0, "R8 hs falls 3 clocks after load", hsBusy, 0);
    rdWr = 1'b0;
    cyc(3);
    check(dataOe == 1'b0, "R5 oe released in write direction", dataOe, 0);
  endtask

  task automatic t_dir_flip;
    rdWr = 1'b0; dataIn = 8'h5A;
    cyc(1);
    csN = 1'b0;
    cyc(3);
    rdWr = 1'b1;
    cyc(3);
    csN = 1'b1;
    cyc(3);
    check(wrValid == 1'b1 && wrData == 8'h5A, "R2 completed as write", wrData, 8'h5A);
    check(rdReady == 1'b0 && dataOut == 8'h81, "R2 read byte not consumed", rdReady, 0);
    rdWr = 1'b0;
    cyc(4);
  endtask

  task automatic t_busy_ignore;
    access(1'b0, 8'hEE);
    cyc(4);
    check(errFlag == 1'b1, "R10 error set", errFlag, 1);
    check(wrData == 8'h5A && wrValid == 1'b1, "R10 byte not overwritten", wrData, 8'h5A);
    wrReady = 1'b1;
    cyc(1);
    wrReady = 1'b0;
    cyc(1);
    check(hsBusy == 1'b0 && wrValid == 1'b0, "R10 no new capture", {hsBusy, wrValid}, 0);
    check(errFlag == 1'b1, "R10 error sticky", errFlag, 1);
    errClr = 1'b1;
    cyc(1);
    errClr = 1'b0;
    check(errFlag == 1'b0, "R10 error cleared", errFlag, 0);
  endtask

  task automatic t_back_to_back;
    wrReady = 1'b1;
    access(1'b0, 8'h17);
    cyc(3);
    check(hsBusy == 1'b1, "R4 hs up", hsBusy, 1);
    cyc(3);
    check(hsBusy == 1'b1, "R4 hs still up after 3 clocks", hsBusy, 1);
    check(wrData == 8'h17, "R6 back-to-back capture", wrData, 8'h17);
    cyc(1);
    check(hsBusy == 1'b0, "R4 hs high exactly 4 clocks", hsBusy, 0);
    wrReady = 1'b0;
  endtask

  initial begin
    t_reset();
    t_write();
    t_read();
    t_dir_flip();
    t_busy_ignore();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule